// File: doc/BRIEF.md
# Signed Integer ALU with Condition Flags

This block is the execute-stage arithmetic unit of a small teaching processor. Each cycle it takes two register operands and a function code, and it returns the result in the same cycle. Operand A comes from the first register field of the instruction and operand B from the second. Four functions are supported: addition, subtraction, bitwise AND and bitwise XOR. Subtraction produces B minus A, so the result can replace the second register in the usual way. Both operands always come from registers.

Next to the datapath sits a three-bit flag register with zero, sign and overflow bits. There is no carry bit, and all comparisons treat the operands as signed two's-complement numbers. The flags are loaded on the clock edge, and only when the control logic marks the instruction as arithmetic or logical. A branch-condition evaluator reads the stored flags and raises a single "condition holds" output. Conditional jumps and conditional moves use that output. A test made in the same cycle as a flag write still sees the old flags.

Top module: `alu_cc_unit`

## Requirements
- R1: With function code 0 the result equals A + B, modulo 2^WIDTH.
- R2: With function code 1 the result equals B - A, modulo 2^WIDTH.
- R3: Function code 2 gives A AND B, and function code 3 gives A XOR B.
- R4: On a clock edge where flag_we is high and the function code is 0 to 3, the zero flag becomes 1 exactly when the result is all zeros, and the sign flag takes the result's top bit.
- R5: On such an edge the overflow flag records signed overflow. For an add, overflow means the operands share a sign and the result's sign differs from it. For a subtract, it means B and A differ in sign and the result's sign differs from B's. AND and XOR always load 0 into the overflow flag.
- R6: The flags keep their value when flag_we is low, and also when the function code is 4 to 15. Function codes 4 to 15 drive a result of zero.
- R7: While reset is asserted, the flags are zero=1, sign=0, overflow=0.
- R8: cond_true_o follows the 4-bit cond_i code: 0 always true; 1 (sign^ovf)|zero; 2 sign^ovf; 3 zero; 4 not zero; 5 not (sign^ovf); 6 not (sign^ovf) and not zero; 7 to 15 always false.
- R9: cond_true_o is computed from the registered flags. A flag write becomes visible to the condition output one cycle after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| opnd_a_i | input | WIDTH | Operand from the first register field |
| opnd_b_i | input | WIDTH | Operand from the second register field |
| func_i | input | 4 | Function select: 0 add, 1 subtract, 2 AND, 3 XOR |
| flag_we_i | input | 1 | Load the flags from this cycle's result |
| cond_i | input | 4 | Condition code to evaluate |
| result_o | output | WIDTH | Combinational result |
| zero_o | output | 1 | Stored zero flag |
| sign_o | output | 1 | Stored sign flag |
| ovf_o | output | 1 | Stored overflow flag |
| cond_true_o | output | 1 | Selected condition holds on the stored flags |

## Verification
The bench builds the unit with its default WIDTH of 32, so the exact boundary operands from the requirements can be applied. These are 0x7FFFFFFF plus 1 and 0x80000000 minus 1, which overflow in opposite directions, and two minimum negatives summed to zero. Equal operands are also subtracted to set the zero flag. The bench then walks all sixteen condition codes against several stored flag combinations, including codes 7 to 15. It also issues writes in the same cycle as condition tests, to show the one-cycle lag.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    typedef enum logic [3:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_XOR = 4'd3
    } alu_fn_e;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'd0,
        CC_LE     = 4'd1,
        CC_LT     = 4'd2,
        CC_EQ     = 4'd3,
        CC_NE     = 4'd4,
        CC_GE     = 4'd5,
        CC_GT     = 4'd6
    } cond_code_e;

    typedef struct packed {
        logic zero;
        logic sign;
        logic ovf;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{zero: 1'b1, sign: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_cc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       func_i,
    output logic [WIDTH-1:0] res_o,
    output logic             ovf_o,
    output logic             valid_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] diff_w;

    assign sum_w  = a_i + b_i;
    assign diff_w = b_i - a_i;

    always_comb begin
        res_o   = '0;
        ovf_o   = 1'b0;
        valid_o = 1'b1;
        case (func_i)
            FN_ADD: begin
                res_o = sum_w;
                ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);
            end
            FN_SUB: begin
                res_o = diff_w;
                ovf_o = (a_i[MSB] != b_i[MSB]) && (diff_w[MSB] != b_i[MSB]);
            end
            FN_AND: res_o = a_i & b_i;
            FN_XOR: res_o = a_i ^ b_i;
            default: valid_o = 1'b0;
        endcase
    end

    // R5: a logical function never reports overflow
    always_comb begin
        if (func_i == FN_AND || func_i == FN_XOR) begin
            a_r5_logic_no_ovf: assert (ovf_o == 1'b0);
        end
    end

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import alu_cc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  flags_t flags_i,
    input  logic [3:0] cond_i,
    output logic   hit_o
);
    logic lt_w;

    assign lt_w = flags_i.sign ^ flags_i.ovf;

    always_comb begin
        case (cond_i)
            CC_ALWAYS: hit_o = 1'b1;
            CC_LE:     hit_o = lt_w | flags_i.zero;
            CC_LT:     hit_o = lt_w;
            CC_EQ:     hit_o = flags_i.zero;
            CC_NE:     hit_o = ~flags_i.zero;
            CC_GE:     hit_o = ~lt_w;
            CC_GT:     hit_o = ~lt_w & ~flags_i.zero;
            default:   hit_o = 1'b0;
        endcase
    end

    // R8: unconditional code is always true, reserved codes never
    a_r8_always_true: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == CC_ALWAYS) |-> hit_o);
    a_r8_reserved_false: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i > 4'd6) |-> !hit_o);

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a_i,
    input  logic [WIDTH-1:0] opnd_b_i,
    input  logic [3:0]       func_i,
    input  logic             flag_we_i,
    input  logic [3:0]       cond_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             sign_o,
    output logic             ovf_o,
    output logic             cond_true_o
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t state_d, state_q;

    logic [WIDTH-1:0] res_w;
    logic             ovf_w;
    logic             valid_w;

    alu_datapath #(.WIDTH(WIDTH)) u_path (
        .a_i     (opnd_a_i),
        .b_i     (opnd_b_i),
        .func_i  (func_i),
        .res_o   (res_w),
        .ovf_o   (ovf_w),
        .valid_o (valid_w)
    );

    always_comb begin
        state_d = state_q;
        if (flag_we_i && valid_w) begin
            state_d.flags.zero = (res_w == '0);
            state_d.flags.sign = res_w[MSB];
            state_d.flags.ovf  = ovf_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.flags <= FLAGS_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    alu_cond_eval u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (state_q.flags),
        .cond_i  (cond_i),
        .hit_o   (cond_true_o)
    );

    assign result_o = res_w;
    assign zero_o   = state_q.flags.zero;
    assign sign_o   = state_q.flags.sign;
    assign ovf_o    = state_q.flags.ovf;

    // R4: stored zero and sign follow the result of the writing cycle
    a_r4_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && func_i < 4'd4) |=> (zero_o == ($past(result_o) == '0)));
    a_r4_sign_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && func_i < 4'd4) |=> (sign_o == $past(result_o[MSB])));
    // R6: no write enable or an unused function leaves the flags alone
    a_r6_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we_i || func_i > 4'd3) |=> $stable({zero_o, sign_o, ovf_o}));
    a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i > 4'd3) |-> (result_o == '0));
    // R9: equality test reads the stored zero flag
    a_r9_eq_reads_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'd3) |-> (cond_true_o == zero_o));

endmodule

// File: tb/alu_cc_unit_tb.sv
module alu_cc_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  func = '0;
    logic        flag_we = 1'b0;
    logic [3:0]  cond = '0;
    logic [31:0] result;
    logic        zero_f, sign_f, ovf_f, cond_true;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    alu_cc_unit #(.WIDTH(32)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .opnd_a_i    (opnd_a),
        .opnd_b_i    (opnd_b),
        .func_i      (func),
        .flag_we_i   (flag_we),
        .cond_i      (cond),
        .result_o    (result),
        .zero_o      (zero_f),
        .sign_o      (sign_f),
        .ovf_o       (ovf_f),
        .cond_true_o (cond_true)
    );

    typedef struct {
        logic [31:0] res;
        logic [2:0]  flg;
        logic        hit;
        string       rtag;
        string       ftag;
        string       ctag;
    } exp_t;

    exp_t sb_q[$];
    logic m_z = 1'b1, m_s = 1'b0, m_o = 1'b0;

    function automatic logic cc_model(input logic [3:0] c, input logic z, input logic s, input logic o);
        logic lt;
        lt = s ^ o;
        case (c)
            4'd0: return 1'b1;
            4'd1: return lt | z;
            4'd2: return lt;
            4'd3: return z;
            4'd4: return !z;
            4'd5: return !lt;
            4'd6: return !lt && !z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b,
                         input logic we, input logic [3:0] c,
                         input string rtag, input string ftag, input string ctag);
        exp_t e;
        longint sa, sb, wide;
        logic [31:0] r;
        logic o;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        o = 1'b0;
        case (f)
            4'd0: begin wide = sa + sb; r = a + b; o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            4'd1: begin wide = sb - sa; r = b - a; o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
            4'd2: r = a & b;
            4'd3: r = a ^ b;
            default: r = '0;
        endcase
        @(negedge clk);
        opnd_a = a; opnd_b = b; func = f; flag_we = we; cond = c;
        e.res = r;
        e.flg = {m_z, m_s, m_o};
        e.hit = cc_model(c, m_z, m_s, m_o);
        e.rtag = rtag; e.ftag = ftag; e.ctag = ctag;
        sb_q.push_back(e);
        if (we && f < 4'd4) begin
            m_z = (r == 32'd0);
            m_s = r[31];
            m_o = o;
        end
    endtask

    // monitor: compares outputs shortly after each driving edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.rtag, "result", result, e.res);
                check(e.ftag, "flags{z,s,o}", {29'd0, zero_f, sign_f, ovf_f}, {29'd0, e.flg});
                check(e.ctag, "cond_true", {31'd0, cond_true}, {31'd0, e.hit});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R7: reset values while reset is held
        check("R7", "reset flags", {29'd0, zero_f, sign_f, ovf_f}, 32'd4);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R7", "flags after release", {29'd0, zero_f, sign_f, ovf_f}, 32'd4);

        // boundary adds and subtracts
        do_op(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1, 4'd3, "R1", "R7", "R8");
        do_op(4'd1, 32'h0000_0001, 32'h8000_0000, 1'b1, 4'd2, "R2", "R5", "R8");
        do_op(4'd1, 32'h0000_0005, 32'h0000_0005, 1'b1, 4'd6, "R2", "R5", "R8");
        do_op(4'd1, 32'h0000_0009, 32'h0000_0003, 1'b1, 4'd3, "R2", "R4", "R9");
        do_op(4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 4'd2, "R1", "R4", "R9");
        do_op(4'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 1'b1, 4'd3, "R3", "R5", "R9");
        do_op(4'd3, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 4'd5, "R3", "R5", "R8");
        // no write enable, then unused function code with write enable
        do_op(4'd0, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 4'd1, "R1", "R5", "R8");
        do_op(4'd5, 32'h1234_5678, 32'h1234_5678, 1'b1, 4'd4, "R6", "R6", "R8");
        do_op(4'd15, 32'h0000_0000, 32'h0000_0000, 1'b1, 4'd3, "R6", "R6", "R8");
        do_op(4'd3, 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 4'd0, "R3", "R6", "R8");

        // every condition code against several stored flag states
        for (int k = 0; k < 5; k++) begin
            logic [31:0] pa, pb;
            logic [3:0]  pf;
            case (k)
                0: begin pf = 4'd1; pa = 32'd7;          pb = 32'd7;          end
                1: begin pf = 4'd1; pa = 32'd10;         pb = 32'd3;          end
                2: begin pf = 4'd1; pa = 32'd3;          pb = 32'd10;         end
                3: begin pf = 4'd1; pa = 32'h0000_0001;  pb = 32'h8000_0000;  end
                default: begin pf = 4'd0; pa = 32'h8000_0000; pb = 32'hFFFF_FFFF; end
            endcase
            do_op(pf, pa, pb, 1'b1, 4'd0, "R2", "R4", "R8");
            for (int c = 0; c < 16; c++) begin
                do_op(4'd2, 32'h0F0F_0F0F, 32'h00FF_00FF, 1'b0, c[3:0], "R3", "R6", "R8");
            end
        end

        // same-cycle write and test, back to back
        do_op(4'd1, 32'd4, 32'd4, 1'b1, 4'd3, "R2", "R5", "R9");
        do_op(4'd0, 32'd1, 32'd1, 1'b1, 4'd3, "R1", "R4", "R9");
        do_op(4'd0, 32'd0, 32'd0, 1'b0, 4'd4, "R1", "R4", "R9");

        repeat (3) @(negedge clk);
        #2;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule